// File: doc/BRIEF.md
# Write-First Read Wrapper for a Read-First RAM

This block puts write-first read behaviour around a synchronous RAM whose own read port returns the old contents of a word that is being written in the same cycle. It has one write port and one read port, and both run on one clock edge. The write port has an address, a data word and one write-enable bit per lane. The read port has an address and returns its word one clock later.

The wrapper registers the write word on every cycle. It also registers a lane mask: the write-enable vector when the two addresses are equal, and zero otherwise. On the next cycle each lane of the read word comes from the registered write data if its mask bit is set, and from the RAM output if it is not. A partial write to the word being read therefore shows new data only in the lanes that were written.

The block has no handshake. Both ports accept an operation on every clock, so there is no back-pressure. `DBITS` must divide evenly by `EN_BITS`, and elaboration stops if it does not. A second write port or a separate read clock has no place in this structure.

Top module: `wf_ram_wrap`

## Requirements
- R1: `rd_data` has a latency of one clock. When no write is enabled, the value after a rising edge is the word stored at the `rd_addr` sampled on that edge.
- R2: A write with every enable bit set, to the address being read in the same cycle, returns that cycle's `wr_data` on `rd_data` after the edge.
- R3: A write with only some enable bits set, to the address being read in the same cycle, returns new data in the enabled lanes and the previous stored contents in the other lanes. Lane i is bits `[i*DBITS/EN_BITS +: DBITS/EN_BITS]` and is controlled by `wr_en[i]`.
- R4: A write to an address other than `rd_addr` does not change the read result. The read returns the word stored before that edge.
- R5: When `wr_en` is all zeros, nothing is stored and nothing is bypassed, even if `wr_addr` equals `rd_addr`. A later read of that address returns the earlier contents.
- R6: A partial write updates only the enabled lanes of the stored word. A later read returns the merged word.
- R7: While reset is held, and after reset until the first edge, `rd_data` is zero and the bypass lane mask is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | EN_BITS | Write enable, one bit per lane |
| wr_addr | input | ABITS | Write address |
| wr_data | input | DBITS | Write data word |
| rd_addr | input | ABITS | Read address |
| rd_data | output | DBITS | Read word, one clock after `rd_addr` |

## Verification
The hardest case to reach is a partial write to the very address being read. The lanes that were not written must then keep older data, and that data must itself come from an earlier partial write. Random traffic over a wide address space rarely lines these events up.

The stimulus therefore fills the RAM first, so that every later read is defined. It then confines random write and read addresses to a small window, and sets the read address equal to the write address half the time. Enable vectors are random, which covers mixed-lane words in many combinations. Directed steps add an all-zero enable at a matching address and a read of a merged word taken later.

// File: rtl/wf_pkg.sv
package wf_pkg;
  // Width of one enable lane for a data word of d bits split by e enables.
  function automatic int lane_width(input int d, input int e);
    return d / e;
  endfunction
endpackage

// File: rtl/wf_ram_core.sv
module wf_ram_core #(
  parameter int ABITS   = 4,
  parameter int DBITS   = 16,
  parameter int EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [DBITS-1:0]   rd_q
);
  localparam int DEPTH = 1 << ABITS;
  localparam int LW    = wf_pkg::lane_width(DBITS, EN_BITS);

  logic [DBITS-1:0] store [DEPTH];

  // Lane-wise write; the read register below samples the pre-write word.
  always_ff @(posedge clk) begin
    for (int l = 0; l < EN_BITS; l++) begin
      if (wr_en[l]) store[wr_addr][l*LW +: LW] <= wr_data[l*LW +: LW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= store[rd_addr];
  end
endmodule

// File: rtl/wf_bypass_regs.sv
module wf_bypass_regs #(
  parameter int ABITS   = 4,
  parameter int DBITS   = 16,
  parameter int EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [DBITS-1:0]   data_q,
  output logic [EN_BITS-1:0] mask_q
);
  logic               addr_hit;
  logic [EN_BITS-1:0] mask_d;

  assign addr_hit = (wr_addr == rd_addr);
  assign mask_d   = addr_hit ? wr_en : '0;

  // The data copy loads every cycle; only the mask decides whether it is used.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= '0;
    end else begin
      data_q <= wr_data;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/wf_lane_mux.sv
module wf_lane_mux #(
  parameter int DBITS   = 16,
  parameter int EN_BITS = 4
) (
  input  logic [EN_BITS-1:0] sel,
  input  logic [DBITS-1:0]   fresh,
  input  logic [DBITS-1:0]   stale,
  output logic [DBITS-1:0]   dout
);
  localparam int LW = wf_pkg::lane_width(DBITS, EN_BITS);

  for (genvar g = 0; g < EN_BITS; g++) begin : g_lane
    assign dout[g*LW +: LW] = sel[g] ? fresh[g*LW +: LW] : stale[g*LW +: LW];
  end
endmodule

// File: rtl/wf_ram_wrap.sv
module wf_ram_wrap #(
  parameter int ABITS   = 4,
  parameter int DBITS   = 16,
  parameter int EN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_BITS-1:0] wr_en,
  input  logic [ABITS-1:0]   wr_addr,
  input  logic [DBITS-1:0]   wr_data,
  input  logic [ABITS-1:0]   rd_addr,
  output logic [DBITS-1:0]   rd_data
);
  if ((DBITS % EN_BITS) != 0) begin : g_bad_lanes
    $error("wf_ram_wrap: DBITS must be an exact multiple of EN_BITS");
  end

  logic [DBITS-1:0]   ram_q;
  logic [DBITS-1:0]   byp_data;
  logic [EN_BITS-1:0] lane_mask;

  wf_ram_core #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  wf_bypass_regs #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_byp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .data_q(byp_data), .mask_q(lane_mask)
  );

  wf_lane_mux #(.DBITS(DBITS), .EN_BITS(EN_BITS)) u_mux (
    .sel(lane_mask), .fresh(byp_data), .stale(ram_q), .dout(rd_data)
  );
endmodule

// File: rtl/wf_ram_wrap_chk.sv
module wf_ram_wrap_chk #(
  parameter int ABITS   = 4,
  parameter int DBITS   = 16,
  parameter int EN_BITS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [EN_BITS-1:0] wr_en,
  input logic [ABITS-1:0]   wr_addr,
  input logic [DBITS-1:0]   wr_data,
  input logic [ABITS-1:0]   rd_addr,
  input logic [DBITS-1:0]   rd_data,
  input logic [EN_BITS-1:0] mask_q
);
  // R2: full-width write to the address being read comes straight back.
  p_full_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_addr == rd_addr) && (&wr_en)) |=> (rd_data == $past(wr_data)));

  // R4: differing addresses leave no bypass lane armed.
  p_miss_no_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr != rd_addr) |=> (mask_q == '0));

  // R5: an all-zero enable arms nothing.
  p_idle_no_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> (mask_q == '0));

  // R3: only lanes that were enabled may be bypassed.
  p_mask_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & ~$past(wr_en)) == '0));

  // R7: leaving reset finds the output and the mask cleared.
  p_reset_clear_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> ((mask_q == '0) && (rd_data == '0)));
endmodule

bind wf_ram_wrap wf_ram_wrap_chk #(.ABITS(ABITS), .DBITS(DBITS), .EN_BITS(EN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .mask_q(lane_mask)
);

// File: tb/test_wf_ram_wrap.sv
module test_wf_ram_wrap;
  localparam int AB = 4;
  localparam int DB = 16;
  localparam int EN = 4;
  localparam int LW = DB / EN;
  localparam int DEPTH = 1 << AB;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [EN-1:0] wr_en = '0;
  logic [AB-1:0] wr_addr = '0;
  logic [DB-1:0] wr_data = '0;
  logic [AB-1:0] rd_addr = '0;
  logic [DB-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DB-1:0] model [DEPTH];

  wf_ram_wrap #(.ABITS(AB), .DBITS(DB), .EN_BITS(EN)) i_wf_ram_wrap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Write-first reference: lanes in sel take new, others keep old.
  function automatic logic [DB-1:0] merge(input logic [DB-1:0] old_w,
                                          input logic [DB-1:0] new_w,
                                          input logic [EN-1:0] sel);
    logic [DB-1:0] r;
    r = old_w;
    for (int l = 0; l < EN; l++) if (sel[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  function automatic string classify(input logic [EN-1:0] wen,
                                     input logic [AB-1:0] wa,
                                     input logic [AB-1:0] ra);
    if (wen == '0) return "R1";
    if (wa != ra)  return "R4";
    if (&wen)      return "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [DB-1:0] act, input logic [DB-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic [EN-1:0] wen, input logic [AB-1:0] wa,
                      input logic [DB-1:0] wd, input logic [AB-1:0] ra,
                      input string tag);
    logic [DB-1:0] exp;
    wr_en = wen; wr_addr = wa; wr_data = wd; rd_addr = ra;
    exp = merge(model[ra], wd, (wa == ra) ? wen : '0);
    model[wa] = merge(model[wa], wd, wen);
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R7", rd_data, '0);          // R7 while reset held
    rst_n = 1'b1;
    #1;
    check("R7", rd_data, '0);          // R7 before first edge after reset
    @(negedge clk);

    // Fill every word, reading the same address (R2 bypass).
    for (int a = 0; a < DEPTH; a++)
      step({EN{1'b1}}, AB'(a), DB'($urandom), AB'(a), "R2");

    step('0, 4'd0, 16'hFFFF, 4'd3, "R1");              // R1 plain read
    step(4'hF, 4'd5, 16'hA5A5, 4'd6, "R4");            // R4 other address
    step('0, 4'd0, 16'h0, 4'd5, "R1");
    step(4'b0101, 4'd7, 16'h1234, 4'd7, "R3");         // R3 partial hit
    step('0, 4'd0, 16'h0, 4'd7, "R6");                 // R6 merged word
    step(4'b1000, 4'd7, 16'hBEEF, 4'd7, "R3");
    step('0, 4'd1, 16'h0, 4'd7, "R6");
    step('0, 4'd2, 16'hDEAD, 4'd2, "R5");              // R5 no-enable hit
    step('0, 4'd0, 16'h0, 4'd2, "R5");

    for (int i = 0; i < 3000; i++) begin
      logic [EN-1:0] wen;
      logic [AB-1:0] wa, ra;
      wen = EN'($urandom);
      wa  = AB'($urandom % 4);
      ra  = ($urandom % 2 == 0) ? wa : AB'($urandom % 4);
      step(wen, wa, DB'($urandom), ra, classify(wen, wa, ra));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule